// File: doc/BRIEF.md
# Output-Stationary Multiply-Accumulate Grid

This block is a rectangular grid of multiply-accumulate cells for computing a matrix product C = A x B. Each cell owns one element of C and keeps it in a local running sum. Values of A enter on the left edge, one lane per row, and shift one cell to the right on every clock. Values of B enter on the top edge, one lane per column, and shift one cell down on every clock. The grid has fixed dimensions, so the number of cycles to a complete product is the same on every run.

A feeder outside the block skews the edge streams. Row lane r carries A[r][k] in feed step k + r. Column lane c carries B[k][c] in feed step k + c. Both lanes carry zero outside those steps. A start pulse clears every cell and begins a run. Feed step 0 is the cycle after the start cycle. When the run ends, a done flag rises and stays high. A select index then chooses which cell's sum appears in a registered result port.

Top module: `sa_array`

## Requirements
- R1: The parameters ROWS, COLS, DW (operand width) and DEPTH (inner dimension K) size the grid. The result port is 2*DW + clog2(DEPTH) bits wide, which is 18 bits at the defaults 4, 4, 8 and 4.
- R2: While reset is held, done is 0 and result is 0.
- R3: A start pulse clears every cell sum and the run counter. If start arrives while a run is in progress, the run restarts. If start falls in the cycle in which done would rise, start takes priority: done stays 0 and the new run begins.
- R4: Each cell registers the operands it receives and passes them on. The A value reaches the cell on the right one cycle later, and the B value reaches the cell below one cycle later. Cells in column 0 take the left lane directly, and cells in row 0 take the top lane directly.
- R5: In every cycle that is not a start cycle, each cell adds the unsigned product of its current left operand and its current top operand to its sum.
- R6: Let the start pulse be sampled at edge 0. Done is 0 after edge DEPTH+ROWS+COLS-2 and is 1 after edge DEPTH+ROWS+COLS-1. Done then holds until the next start.
- R7: The result register loads the sum of cell index sel on every clock, where index = r*COLS + c (row-major order). When the skewed feed contract is kept, that sum equals element C[r][c] of the product.
- R8: A sel value of ROWS*COLS or above makes the result register load 0 on the next clock.
- R9: A cell sum never wraps. DEPTH products of full-scale operands fit: with all operands equal to 255 at the defaults, each result reads 260100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that clears the grid and begins a run |
| left_in | input | ROWS*DW | Skewed A lanes; row r occupies bits [r*DW +: DW] |
| top_in | input | COLS*DW | Skewed B lanes; column c occupies bits [c*DW +: DW] |
| sel | input | clog2(ROWS*COLS+1) | Row-major index of the cell to read |
| result | output | 2*DW+clog2(DEPTH) | Registered sum of the selected cell |
| done | output | 1 | High from the end of a run until the next start |

## Verification
The run counter finishing and a fresh start pulse can fall in the same cycle. The bench provokes this by driving start in exactly the cycle after the last feed step, which is when done would otherwise rise. The outcome is judged by two checks. First, done must stay low after that edge. Second, the following run, fed with full-scale operands, must produce exactly the expected sums, which shows that no value from the earlier run survived the restart.

// File: rtl/sa_pkg.sv
package sa_pkg;
   // Sum width that holds k products of two dw-bit unsigned operands without wrapping.
   function automatic int sum_width(input int dw, input int k);
      return 2 * dw + $clog2(k);
   endfunction
endpackage

// File: rtl/sa_pe.sv
module sa_pe #(
   parameter int DW = 8,
   parameter int AW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [DW-1:0] a_in,
   input  logic [DW-1:0] b_in,
   output logic [DW-1:0] a_out,
   output logic [DW-1:0] b_out,
   output logic [AW-1:0] acc
);
   localparam int PW = 2 * DW;

   logic [PW-1:0] prod;

   always_comb prod = PW'(a_in) * PW'(b_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_out <= '0;
         b_out <= '0;
         acc   <= '0;
      end else if (clr) begin
         a_out <= '0;
         b_out <= '0;
         acc   <= '0;
      end else begin
         a_out <= a_in;
         b_out <= b_in;
         acc   <= acc + AW'(prod);
      end
   end

   // R3: a start cycle leaves the sum at zero
   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> acc == '0);
   // R4: operands move on with exactly one register of delay
   assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (a_out == $past(a_in)) && (b_out == $past(b_in)));
   // R9: the sum only grows between clears
   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> acc >= $past(acc));
endmodule

// File: rtl/sa_grid.sv
module sa_grid #(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   parameter int DW   = 8,
   parameter int AW   = 18
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic [ROWS*DW-1:0]      left_in,
   input  logic [COLS*DW-1:0]      top_in,
   output logic [ROWS*COLS*AW-1:0] acc_flat
);
   logic [DW-1:0] a_link [ROWS][COLS+1];
   logic [DW-1:0] b_link [ROWS+1][COLS];

   for (genvar r = 0; r < ROWS; r++) begin : g_left
      assign a_link[r][0] = left_in[r*DW +: DW];
   end
   for (genvar c = 0; c < COLS; c++) begin : g_top
      assign b_link[0][c] = top_in[c*DW +: DW];
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         sa_pe #(.DW(DW), .AW(AW)) u_pe (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .a_in  (a_link[r][c]),
            .b_in  (b_link[r][c]),
            .a_out (a_link[r][c+1]),
            .b_out (b_link[r+1][c]),
            .acc   (acc_flat[(r*COLS+c)*AW +: AW])
         );
      end
   end

   // R4: the operands leaving the right and bottom edges are zero right after a clear
   for (genvar r = 0; r < ROWS; r++) begin : g_redge
      assert_edge_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> a_link[r][COLS] == '0);
   end
   for (genvar c = 0; c < COLS; c++) begin : g_bedge
      assert_edge_bottom_R4: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> b_link[ROWS][c] == '0);
   end
endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl #(
   parameter int LAT = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   localparam int CW = $clog2(LAT + 2);

   logic [CW-1:0] cnt;
   logic          busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else if (start) begin
         cnt  <= '0;
         busy <= 1'b1;
         done <= 1'b0;
      end else if (busy) begin
         if (cnt == CW'(LAT)) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R3: start overrides completion
   assert_start_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done);
   // R6: done holds until a new start
   assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);
endmodule

// File: rtl/sa_gather.sv
module sa_gather #(
   parameter int NPE = 16,
   parameter int AW  = 18,
   parameter int SW  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPE*AW-1:0] acc_flat,
   input  logic [SW-1:0]    sel,
   output logic [AW-1:0]    result
);
   logic [AW-1:0] pick;

   always_comb begin
      pick = '0;
      if (sel < SW'(NPE)) pick = acc_flat[int'(sel)*AW +: AW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) result <= '0;
      else        result <= pick;
   end

   // R8: an index past the last cell reads as zero
   assert_oor_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sel >= SW'(NPE) |=> result == '0);
endmodule

// File: rtl/sa_array.sv
module sa_array #(
   parameter int ROWS  = 4,
   parameter int COLS  = 4,
   parameter int DW    = 8,
   parameter int DEPTH = 4,
   localparam int NPE  = ROWS * COLS,
   localparam int AW   = sa_pkg::sum_width(DW, DEPTH),
   localparam int SW   = $clog2(NPE + 1),
   localparam int LAT  = DEPTH + ROWS + COLS - 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ROWS*DW-1:0] left_in,
   input  logic [COLS*DW-1:0] top_in,
   input  logic [SW-1:0]      sel,
   output logic [AW-1:0]      result,
   output logic               done
);
   // R1: elaboration-time parameter checks
   if (ROWS < 1 || COLS < 1) begin : g_bad_dims
      $error("sa_array: ROWS and COLS must be at least 1");
   end
   if (DW < 1 || DEPTH < 1) begin : g_bad_width
      $error("sa_array: DW and DEPTH must be at least 1");
   end

   logic [NPE*AW-1:0] acc_flat;

   sa_grid #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .AW(AW)) u_grid (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .left_in  (left_in),
      .top_in   (top_in),
      .acc_flat (acc_flat)
   );

   sa_ctrl #(.LAT(LAT)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .done  (done)
   );

   sa_gather #(.NPE(NPE), .AW(AW), .SW(SW)) u_gather (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_flat (acc_flat),
      .sel      (sel),
      .result   (result)
   );

   // R2: outputs are quiet during reset
   always_comb begin
      if (!rst_n) assert_reset_quiet_R2: assert (result == '0 && !done);
   end
endmodule

// File: tb/sa_array_test.sv
`timescale 1ns/1ps
module sa_array_test;
   localparam int ROWS = 4, COLS = 4, DW = 8, DEPTH = 4;
   localparam int LAT = DEPTH + ROWS + COLS - 2;
   localparam int NV  = 4;

   // stimulus table: element [r][k] of A and [k][c] of B sit at byte (row*4+col)
   localparam logic [127:0] A_TAB [NV] = '{
      128'h0102030405060708090A0B0C0D0E0F10,
      128'h00FF00FF7F80017E11223344556677AA,
      128'h13579BDF2468ACE0FEDCBA9876543210,
      128'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF};
   localparam logic [127:0] B_TAB [NV] = '{
      128'h100F0E0D0C0B0A090807060504030201,
      128'hFF00FF00800F7F0199887766554433CC,
      128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0,
      128'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF};

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [ROWS*DW-1:0] left_in = '0;
   logic [COLS*DW-1:0] top_in = '0;
   logic [4:0]         sel = '0;
   logic [17:0]        result;
   logic               done;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   sa_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .left_in(left_in),
      .top_in(top_in), .sel(sel), .result(result), .done(done));

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int unsigned expv(input int v, input int r, input int c);
      int unsigned s = 0;
      for (int k = 0; k < DEPTH; k++)
         s += A_TAB[v][(r*4+k)*8 +: 8] * B_TAB[v][(k*4+c)*8 +: 8];
      return s;
   endfunction

   task automatic pulse_start();
      start = 1'b1; left_in = '0; top_in = '0;
      @(negedge clk);
      start = 1'b0;
   endtask

   // R4 skew contract: row r carries A[r][t-r], column c carries B[t-c][c]
   task automatic feed(input int v);
      for (int t = 0; t < LAT; t++) begin
         for (int r = 0; r < ROWS; r++) begin
            int k = t - r;
            left_in[r*DW +: DW] = (k >= 0 && k < DEPTH) ? A_TAB[v][(r*4+k)*8 +: 8] : 8'd0;
         end
         for (int c = 0; c < COLS; c++) begin
            int k = t - c;
            top_in[c*DW +: DW] = (k >= 0 && k < DEPTH) ? B_TAB[v][(k*4+c)*8 +: 8] : 8'd0;
         end
         @(negedge clk);
      end
      left_in = '0; top_in = '0;
   endtask

   task automatic finish_and_walk(input int v);
      chk("R6 done low one edge early", done, 0);
      @(negedge clk);
      chk("R6 done high at latency", done, 1);
      for (int i = 0; i < ROWS*COLS; i++) begin
         sel = 5'(i);
         @(negedge clk);
         chk("R7 R5 selected sum", result, expv(v, i / COLS, i % COLS));
      end
      chk("R6 done held", done, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R2 reset result", result, 0);
      chk("R2 reset done", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 result width", $bits(result), 18);

      // table walk
      for (int v = 0; v < 3; v++) begin
         pulse_start();
         feed(v);
         finish_and_walk(v);
         sel = 5'd16;
         @(negedge clk);
         chk("R8 sel 16 reads zero", result, 0);
         sel = 5'd31;
         @(negedge clk);
         chk("R8 sel 31 reads zero", result, 0);
      end

      // R3: start lands in the cycle done would rise
      pulse_start();
      feed(0);
      pulse_start();
      chk("R3 start beats done", done, 0);
      feed(3);
      finish_and_walk(3);
      sel = 5'd15;
      @(negedge clk);
      chk("R9 full-scale sum", result, 260100);

      // R3: restart in the middle of a run
      pulse_start();
      feed(1);
      pulse_start();
      feed(2);
      finish_and_walk(2);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #800000;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule